// File: doc/BRIEF.md
# Dual-Stream Time-Division Concentrator

This block interleaves two serial bit streams into one composite stream on a shared system clock. Each stream is buffered upstream in its own one-bit FIFO, written in that stream's clock domain; this block sits on the read side of both FIFOs. It sees each FIFO's data bit, its output-ready flag, its half-full flag and its combined almost-full/almost-empty flag. The system clock must run at no less than the sum of the two mean input rates, and both inputs share the same mean rate. The FIFOs absorb input jitter and align the two phase-independent inputs.

The system clock is divided into alternating slots, the first stream's slot first. A channel is left idle until its start condition has been seen once after reset. In half-full mode that condition is the half-full flag high. In edge-flag mode it is the almost-full/almost-empty flag low, which comes sooner. Once a channel is running, a read in its slot is withheld whenever its fill flags report a low level, and also whenever its FIFO has no ready bit. Each withheld slot goes out as a stuff position, so the downstream framer can regulate the output rate by pulse stuffing.

Top module: `tdm_concentrator`

## Requirements
- R1: While `rst` is high (synchronous, active high), after one rising edge `out_bit`, `out_chan` and `out_stuff` are 0, both channels are idle, `a_rd` and `b_rd` are 0, and the slot counter points at channel A (`a_sel`=1, `b_sel`=0).
- R2: `a_sel` and `b_sel` are one-hot. The first cycle after reset is channel A's slot, and ownership swaps on every clock.
- R3: A read strobe (`a_rd`/`b_rd`) is only raised in that channel's own slot, and only when the channel is running, its `*_ordy` is 1 and its fill level is not low.
- R4: A read strobe in cycle n gives, after the edge ending cycle n, `out_bit` equal to that channel's data bit in cycle n, `out_stuff`=0, and `out_chan` equal to the slot owner (0 = A, 1 = B).
- R5: A slot without a read gives, after its edge, `out_stuff`=1, `out_bit`=0 and `out_chan` equal to the slot owner.
- R6: With `mode_edge`=0, a channel starts running at the edge after its `*_half` is seen high. From then on it keeps running until reset, whatever its flags do.
- R7: With `mode_edge`=1, a channel starts running at the edge after its `*_edge` is seen low, and keeps running until reset.
- R8: With `mode_edge`=0, a running channel whose `*_half` is 0 has its read withheld.
- R9: With `mode_edge`=1, a running channel's read is withheld when `*_edge`=1 and `*_half`=0 (near empty). It is not withheld when `*_edge`=1 and `*_half`=1 (near full).
- R10: A running channel whose `*_ordy` is 0 never gets a read strobe in its slot.
- R11: The channels are independent. A channel that has never met its start condition gets no reads, even while the other channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_edge | input | 1 | 0: half-full flag gates start/fetch; 1: almost-full/almost-empty flag |
| a_half | input | 1 | Channel A FIFO half-full flag |
| a_edge | input | 1 | Channel A FIFO almost-full/almost-empty flag |
| a_ordy | input | 1 | Channel A FIFO output-ready flag |
| a_bit | input | 1 | Channel A FIFO data output |
| b_half | input | 1 | Channel B FIFO half-full flag |
| b_edge | input | 1 | Channel B FIFO almost-full/almost-empty flag |
| b_ordy | input | 1 | Channel B FIFO output-ready flag |
| b_bit | input | 1 | Channel B FIFO data output |
| a_rd | output | 1 | Read enable to channel A FIFO |
| b_rd | output | 1 | Read enable to channel B FIFO |
| a_sel | output | 1 | Current slot belongs to channel A |
| b_sel | output | 1 | Current slot belongs to channel B |
| out_bit | output | 1 | Composite stream bit |
| out_chan | output | 1 | Slot owner of `out_bit` (0 = A, 1 = B) |
| out_stuff | output | 1 | `out_bit` is a stuff position |

## Verification
A channel's start condition can first show up in the very cycle that channel owns the slot. Because the start only takes effect at the following edge, that slot must still be stuffed, and the first real read falls in the channel's next slot. The sweep drives every combination of flags, data and mode through scrambled patterns, with resets at intervals that are not a multiple of the slot period, so a start lands in both the owning slot and the other channel's slot. A reference model in the bench, built from the requirements, decides the expected read strobe. The composite outputs are then compared one edge later.

// File: rtl/tdm_concentrator.sv
module tdm_concentrator (
  input  logic clk,
  input  logic rst,
  input  logic mode_edge,
  input  logic a_half,
  input  logic a_edge,
  input  logic a_ordy,
  input  logic a_bit,
  input  logic b_half,
  input  logic b_edge,
  input  logic b_ordy,
  input  logic b_bit,
  output logic a_rd,
  output logic b_rd,
  output logic a_sel,
  output logic b_sel,
  output logic out_bit,
  output logic out_chan,
  output logic out_stuff
);

  logic       slot;
  logic [1:0] running;

  wire [1:0] half  = {b_half, a_half};
  wire [1:0] edg   = {b_edge, a_edge};
  wire [1:0] ordy  = {b_ordy, a_ordy};
  wire [1:0] dbit  = {b_bit, a_bit};

  wire [1:0] start = mode_edge ? ~edg : half;
  wire [1:0] low   = mode_edge ? (edg & ~half) : ~half;
  wire [1:0] own   = slot ? 2'b10 : 2'b01;
  wire [1:0] fetch = own & running & ordy & ~low;

  assign a_sel = own[0];
  assign b_sel = own[1];
  assign a_rd  = fetch[0];
  assign b_rd  = fetch[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= 1'b0;
      running   <= 2'b00;
      out_bit   <= 1'b0;
      out_chan  <= 1'b0;
      out_stuff <= 1'b0;
    end else begin
      slot      <= ~slot;
      running   <= running | start;
      out_chan  <= slot;
      out_stuff <= ~|fetch;
      out_bit   <= |(fetch & dbit);
    end
  end

endmodule

module tdm_concentrator_chk (
  input logic clk,
  input logic rst,
  input logic a_ordy,
  input logic b_ordy,
  input logic a_bit,
  input logic b_bit,
  input logic a_rd,
  input logic b_rd,
  input logic a_sel,
  input logic b_sel,
  input logic out_bit,
  input logic out_chan,
  input logic out_stuff
);

  // R2
  slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({a_sel, b_sel}) == 1);

  // R2
  slot_swap_chk: assert property (@(posedge clk) disable iff (rst)
    a_sel |=> b_sel);

  // R3
  rd_a_gate_chk: assert property (@(posedge clk) disable iff (rst)
    a_rd |-> (a_sel && a_ordy));

  // R3
  rd_b_gate_chk: assert property (@(posedge clk) disable iff (rst)
    b_rd |-> (b_sel && b_ordy));

  // R4
  fetch_a_out_chk: assert property (@(posedge clk) disable iff (rst)
    a_rd |=> (!out_stuff && !out_chan && out_bit == $past(a_bit)));

  // R4
  fetch_b_out_chk: assert property (@(posedge clk) disable iff (rst)
    b_rd |=> (!out_stuff && out_chan && out_bit == $past(b_bit)));

  // R5
  stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_stuff |-> !out_bit);

  // R10
  no_ready_stuff_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_sel && !a_ordy) || (b_sel && !b_ordy)) |=> out_stuff);

endmodule

bind tdm_concentrator tdm_concentrator_chk u_chk (
  .clk(clk), .rst(rst), .a_ordy(a_ordy), .b_ordy(b_ordy),
  .a_bit(a_bit), .b_bit(b_bit), .a_rd(a_rd), .b_rd(b_rd),
  .a_sel(a_sel), .b_sel(b_sel), .out_bit(out_bit),
  .out_chan(out_chan), .out_stuff(out_stuff)
);

// File: tb/sim_tdm_concentrator.sv
module sim_tdm_concentrator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_edge = 0, a_half = 0, a_edge = 0, a_ordy = 0, a_bit = 0;
  logic b_half = 0, b_edge = 0, b_ordy = 0, b_bit = 0;
  logic a_rd, b_rd, a_sel, b_sel, out_bit, out_chan, out_stuff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_slot, m_run_a, m_run_b;
  logic e_bit, e_chan, e_stuff;

  always #4 clk = ~clk;

  tdm_concentrator u0 (
    .clk(clk), .rst(rst), .mode_edge(mode_edge),
    .a_half(a_half), .a_edge(a_edge), .a_ordy(a_ordy), .a_bit(a_bit),
    .b_half(b_half), .b_edge(b_edge), .b_ordy(b_ordy), .b_bit(b_bit),
    .a_rd(a_rd), .b_rd(b_rd), .a_sel(a_sel), .b_sel(b_sel),
    .out_bit(out_bit), .out_chan(out_chan), .out_stuff(out_stuff)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic string rd_tag(input logic own, input logic run, input logic rdy,
                                   input logic lowv, input logic md, input logic masked);
    if (masked) return "R11";
    if (!own) return "R3";
    if (!run) return md ? "R7" : "R6";
    if (!rdy) return "R10";
    if (lowv) return md ? "R9" : "R8";
    return md ? "R9" : "R6";
  endfunction

  task automatic reset_seq();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "out_bit", out_bit, 1'b0);
    chk("R1", "out_chan", out_chan, 1'b0);
    chk("R1", "out_stuff", out_stuff, 1'b0);
    chk("R1", "a_sel", a_sel, 1'b1);
    chk("R1", "b_sel", b_sel, 1'b0);
    chk("R1", "a_rd", a_rd, 1'b0);
    chk("R1", "b_rd", b_rd, 1'b0);
    rst = 1'b0;
    m_slot = 0; m_run_a = 0; m_run_b = 0;
    e_bit = 0; e_chan = 0; e_stuff = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3000; k++) begin
      logic [8:0] x;
      logic masked, low_a, low_b, f_a, f_b, st_a, st_b;
      if (k % 251 == 0) reset_seq();
      else @(negedge clk);
      // R4 / R5: registered composite outputs from the previous slot
      chk(e_stuff ? "R5" : "R4", "out_stuff", out_stuff, e_stuff);
      chk(e_stuff ? "R5" : "R4", "out_bit", out_bit, e_bit);
      chk("R4", "out_chan", out_chan, e_chan);
      x = 9'((k * 205 + (k / 512) * 77) & 511);
      masked = (k < 1000);
      mode_edge = x[8];
      a_half = x[0]; a_edge = x[1]; a_ordy = x[2]; a_bit = x[3];
      b_half = masked ? 1'b0 : x[4];
      b_edge = masked ? 1'b1 : x[5];
      b_ordy = x[6]; b_bit = x[7];
      #1;
      low_a = mode_edge ? (a_edge & ~a_half) : ~a_half;
      low_b = mode_edge ? (b_edge & ~b_half) : ~b_half;
      f_a = !m_slot && m_run_a && a_ordy && !low_a;
      f_b =  m_slot && m_run_b && b_ordy && !low_b;
      chk("R2", "a_sel", a_sel, !m_slot);
      chk("R2", "b_sel", b_sel, m_slot);
      chk(rd_tag(!m_slot, m_run_a, a_ordy, low_a, mode_edge, 1'b0), "a_rd", a_rd, f_a);
      chk(rd_tag(m_slot, m_run_b, b_ordy, low_b, mode_edge, masked), "b_rd", b_rd, f_b);
      st_a = mode_edge ? !a_edge : a_half;
      st_b = mode_edge ? !b_edge : b_half;
      e_chan = m_slot;
      e_stuff = !(f_a || f_b);
      e_bit = (f_a && a_bit) || (f_b && b_bit);
      m_run_a = m_run_a | st_a;
      m_run_b = m_run_b | st_b;
      m_slot = !m_slot;
    end
    @(negedge clk);
    chk(e_stuff ? "R5" : "R4", "out_stuff", out_stuff, e_stuff);
    chk("R4", "out_bit", out_bit, e_bit);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule